// File: doc/BRIEF.md
# Rotating-Map Fibonacci Shift Register

This block is an N-cell Fibonacci linear feedback shift register whose bits sit in a small storage array and never move between cells. A head pointer records which physical cell currently holds logical position 0, the leftmost cell. Logical position k lives at physical address (head + k) mod N. On each step the block reads the tap cells through this map and XORs them together. It writes the result into the physical cell that held the logical rightmost bit, so that cell becomes the new leftmost. The head pointer then moves down by one, modulo N.

A seed can be loaded in logical order. A load also returns the head pointer to zero. The serial output is the logical rightmost bit. A logical-order view of the whole state is rebuilt through the pointer map, so at the ports the block looks the same as a conventional register that shifts its bits towards the right. Tap positions are set by a mask parameter. The default, three cells with taps at logical positions 1 and 2, realises x^3 + x + 1.

Top module: `lfsr_rotmap`

## Requirements
- R1: After reset, `state_o` equals the `RESET_SEED` parameter (default: bit 0 set, all other bits clear) and `serial_o` is 0.
- R2: When `load_i` is high at a clock edge, `state_o` equals `seed_i` after that edge. Bit k of `seed_i` and of `state_o` is logical position k, and position 0 is the leftmost cell.
- R3: When `step_i` is high and `load_i` is low at a clock edge, the new `state_o[k]` equals the old `state_o[k-1]` for k ≥ 1. The new `state_o[0]` equals the XOR of the old bits whose positions are set in `TAP_MASK`.
- R4: When `step_i` and `load_i` are both low at a clock edge, `state_o` is unchanged.
- R5: `serial_o` always equals `state_o[N-1]`, the logical rightmost cell.
- R6: A step modifies at most one physical storage cell. It moves the head pointer down by one, modulo N, and a load sets the head pointer to 0.
- R7: With the default parameters and seed 100 (positions 0, 1, 2), successive steps produce the state sequence 100, 010, 101, 110, 111, 011, 001. The bits seen on `serial_o` are 0,0,1,0,1,1,1, and this repeats with period 7.
- R8: When `load_i` and `step_i` are both high, the load wins and `state_o` equals `seed_i` after the edge.
- R9: An all-zero seed stays all-zero under any number of steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Advance the register by one position |
| load_i | input | 1 | Load `seed_i`; takes priority over `step_i` |
| seed_i | input | N | Seed in logical order, bit k = position k |
| serial_o | output | 1 | Logical rightmost bit |
| state_o | output | N | Whole state in logical order |

## Verification
The bench drives the default three-cell register from seed 100 for two full periods. It compares every state and every serial bit against a shifting model and against the fixed 0,0,1,0,1,1,1 pattern. This exposes a wrong pointer direction, a wrong write address or a wrong tap set. Steps are interleaved with idle cycles, which shows whether the state holds while the pointer stays parked. Reloads are applied partway through a period, so they happen while the head pointer is not zero; these show whether the load puts the map back to zero. A load and a step issued together check which one has priority. The all-zero seed checks that the register stays locked at zero.

// File: rtl/lfsr_rotmap_pkg.sv
package lfsr_rotmap_pkg;

    // Operation chosen for the current cycle; load outranks step.
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_STEP = 2'd1,
        OP_LOAD = 2'd2
    } lfsr_op_e;

endpackage

// File: rtl/lfsr_head_ctr.sv
module lfsr_head_ctr
    import lfsr_rotmap_pkg::*;
#(
    parameter int N  = 3,
    parameter int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  lfsr_op_e      op,
    output logic [PW-1:0] head_q
);

    localparam logic [PW-1:0] LAST = PW'(N - 1);

    typedef struct packed {
        logic [PW-1:0] head;
    } head_state_t;

    head_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_LOAD: st_d.head = '0;
            OP_STEP: st_d.head = (st_q.head == '0) ? LAST : st_q.head - PW'(1);
            default: st_d.head = st_q.head;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_q = st_q.head;

endmodule

// File: rtl/lfsr_addr_map.sv
module lfsr_addr_map #(
    parameter int N  = 3,
    parameter int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [PW-1:0]        head,
    output logic [N-1:0][PW-1:0] phys
);

    generate
        for (genvar k = 0; k < N; k++) begin : g_pos
            logic [PW:0] sum;
            always_comb begin
                sum = {1'b0, head} + (PW + 1)'(k);
                if (sum >= (PW + 1)'(N)) sum = sum - (PW + 1)'(N);
                phys[k] = sum[PW-1:0];
            end
        end
    endgenerate

endmodule

// File: rtl/lfsr_cell_array.sv
module lfsr_cell_array
    import lfsr_rotmap_pkg::*;
#(
    parameter int           N          = 3,
    parameter int           PW         = (N > 1) ? $clog2(N) : 1,
    parameter logic [N-1:0] RESET_SEED = N'(1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  lfsr_op_e      op,
    input  logic [PW-1:0] wr_addr,
    input  logic          wr_bit,
    input  logic [N-1:0]  seed,
    output logic [N-1:0]  cells_q
);

    typedef struct packed {
        logic [N-1:0] bits;
    } cell_state_t;

    cell_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (op)
            // Head returns to zero on load, so physical order equals logical order.
            OP_LOAD: st_d.bits = seed;
            OP_STEP: st_d.bits[wr_addr] = wr_bit;
            default: st_d.bits = st_q.bits;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.bits <= RESET_SEED;
        else        st_q <= st_d;
    end

    assign cells_q = st_q.bits;

endmodule

// File: rtl/lfsr_rotmap.sv
module lfsr_rotmap
    import lfsr_rotmap_pkg::*;
#(
    parameter int           N          = 3,
    parameter logic [N-1:0] TAP_MASK   = 3'b110,
    parameter logic [N-1:0] RESET_SEED = N'(1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_i,
    input  logic         load_i,
    input  logic [N-1:0] seed_i,
    output logic         serial_o,
    output logic [N-1:0] state_o
);

    localparam int PW = (N > 1) ? $clog2(N) : 1;

    lfsr_op_e              op;
    logic [PW-1:0]         head_q;
    logic [N-1:0][PW-1:0]  phys;
    logic [N-1:0]          cells_q;
    logic                  fb_bit;

    always_comb begin
        if (load_i)      op = OP_LOAD;
        else if (step_i) op = OP_STEP;
        else             op = OP_IDLE;
    end

    lfsr_head_ctr #(.N(N), .PW(PW)) u_head (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .head_q (head_q)
    );

    lfsr_addr_map #(.N(N), .PW(PW)) u_map (
        .head (head_q),
        .phys (phys)
    );

    // Logical view rebuilt through the rotating map.
    always_comb begin
        for (int k = 0; k < N; k++) state_o[k] = cells_q[phys[k]];
    end

    assign fb_bit   = ^(state_o & TAP_MASK);
    assign serial_o = state_o[N-1];

    lfsr_cell_array #(.N(N), .PW(PW), .RESET_SEED(RESET_SEED)) u_cells (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .wr_addr (phys[N-1]),
        .wr_bit  (fb_bit),
        .seed    (seed_i),
        .cells_q (cells_q)
    );

endmodule

// File: rtl/lfsr_rotmap_chk.sv
module lfsr_rotmap_chk #(
    parameter int           N        = 3,
    parameter int           PW       = 2,
    parameter logic [N-1:0] TAP_MASK = 3'b110
) (
    input logic          clk,
    input logic          rst_n,
    input logic          step_i,
    input logic          load_i,
    input logic [N-1:0]  seed_i,
    input logic          serial_o,
    input logic [N-1:0]  state_o,
    input logic [N-1:0]  cells_q,
    input logic [PW-1:0] head_q
);

    // R2
    load_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> state_o == $past(seed_i));

    // R3
    shift_body_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> state_o[N-1:1] == $past(state_o[N-2:0]));

    // R3
    feedback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> state_o[0] == ^($past(state_o) & TAP_MASK));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !load_i) |=> $stable(state_o));

    // R5
    serial_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        serial_o == state_o[N-1]);

    // R6
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> $countones(cells_q ^ $past(cells_q)) <= 1);

    // R6
    head_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=>
            head_q == (($past(head_q) == '0) ? PW'(N - 1) : $past(head_q) - PW'(1)));

    // R6
    head_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> head_q == '0);

endmodule

bind lfsr_rotmap lfsr_rotmap_chk #(.N(N), .PW(PW), .TAP_MASK(TAP_MASK)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_i   (step_i),
    .load_i   (load_i),
    .seed_i   (seed_i),
    .serial_o (serial_o),
    .state_o  (state_o),
    .cells_q  (cells_q),
    .head_q   (head_q)
);

// File: tb/sim_lfsr_rotmap.sv
`timescale 1ns/100ps
module sim_lfsr_rotmap;

    localparam int           N   = 3;
    localparam logic [N-1:0] TAP = 3'b110;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         step_i = 1'b0;
    logic         load_i = 1'b0;
    logic [N-1:0] seed_i = '0;
    logic         serial_o;
    logic [N-1:0] state_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [N-1:0] st;
        int           req;
    } exp_item_t;

    exp_item_t    sb_q[$];
    logic [N-1:0] model;

    always #2.5 clk = ~clk;

    lfsr_rotmap #(.N(N), .TAP_MASK(TAP)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (step_i),
        .load_i   (load_i),
        .seed_i   (seed_i),
        .serial_o (serial_o),
        .state_o  (state_o)
    );

    // Driver: set inputs for one edge and push the expected result.
    task automatic drive(input bit stp, input bit ld, input logic [N-1:0] sd, input int req);
        exp_item_t it;
        @(negedge clk);
        step_i = stp;
        load_i = ld;
        seed_i = sd;
        if (ld)       model = sd;                              // R2 R8
        else if (stp) model = {model[N-2:0], ^(model & TAP)};  // R3 R6
        it.st  = model;
        it.req = req;
        sb_q.push_back(it);
    endtask

    // Monitor: pop and compare after every edge that has an expected item.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_item_t it;
                it = sb_q.pop_front();
                checks++;
                if (state_o !== it.st) begin
                    failures++;
                    $display("FAIL R%0d state actual=%b expected=%b", it.req, state_o, it.st);
                end
                checks++;
                if (serial_o !== it.st[N-1]) begin  // R5
                    failures++;
                    $display("FAIL R5 serial actual=%b expected=%b", serial_o, it.st[N-1]);
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    localparam logic [6:0] SER_PAT = 7'b1110100; // bit i = serial bit i: 0,0,1,0,1,1,1

    initial begin
        logic [N-1:0] r7_states [7];
        r7_states[0] = 3'b001; r7_states[1] = 3'b010; r7_states[2] = 3'b101;
        r7_states[3] = 3'b011; r7_states[4] = 3'b111; r7_states[5] = 3'b110;
        r7_states[6] = 3'b100;  // written as {pos2,pos1,pos0}

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        checks++;
        if (state_o !== 3'b001 || serial_o !== 1'b0) begin
            failures++;
            $display("FAIL R1 actual=%b/%b expected=001/0", state_o, serial_o);
        end
        model = 3'b001;

        // R7: two full periods, serial pattern and logical states checked directly
        for (int i = 0; i < 14; i++) begin
            checks++;
            if (serial_o !== SER_PAT[i % 7] || state_o !== r7_states[i % 7]) begin
                failures++;
                $display("FAIL R7 step=%0d actual=%b/%b expected=%b/%b",
                         i, state_o, serial_o, r7_states[i % 7], SER_PAT[i % 7]);
            end
            drive(1'b1, 1'b0, '0, 3);  // R3 R6 via scoreboard
            @(posedge clk); #1;
        end
        drive(1'b0, 1'b0, '0, 4);

        // R4: idle cycles interleaved with steps
        for (int i = 0; i < 6; i++) begin
            drive(1'b1, 1'b0, '0, 3);
            drive(1'b0, 1'b0, '0, 4);
            drive(1'b0, 1'b0, '0, 4);
        end

        // R2 R6: reloads with head pointer away from zero
        drive(1'b1, 1'b0, '0, 3);
        drive(1'b0, 1'b1, 3'b110, 2);
        for (int i = 0; i < 5; i++) drive(1'b1, 1'b0, '0, 3);
        drive(1'b0, 1'b1, 3'b011, 2);
        for (int i = 0; i < 4; i++) drive(1'b1, 1'b0, '0, 3);

        // R8: load and step together
        drive(1'b1, 1'b1, 3'b101, 8);
        drive(1'b1, 1'b0, '0, 3);
        drive(1'b1, 1'b1, 3'b010, 8);

        // R9: all-zero seed locks
        drive(1'b0, 1'b1, 3'b000, 2);
        for (int i = 0; i < 5; i++) drive(1'b1, 1'b0, '0, 9);

        drive(1'b0, 1'b0, '0, 4);
        wait (sb_q.size() == 0);
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule